// File: doc/BRIEF.md
# Address-Decoded Request Crossbar

This block carries requests from several initiator-side ports to several target-side ports. Each request's address is compared against a table of half-open address windows, one window per target, supplied on input pins. The lowest-numbered window that contains the address picks the target. A catch-all port, numbered one above the last regular target, takes every address that falls outside all windows.

Every target port owns an occupancy layer. A layer takes at most one request per cycle. It then stays occupied for as many cycles as the payload needs, one beat per `BEAT_BYTES` bytes. If a request meets an occupied layer, the request is refused and its source is remembered. Once the layer frees, the remembered sources receive a one-cycle retry pulse, one at a time in round-robin order, and the pulsed source holds the layer until it is accepted. When a target itself refuses a request, the layer stays held until that target raises its own retry input.

Forwarded requests carry their header delay increased by the fixed front-end and forward latencies. A packet counter and a byte counter are kept for every pair of source and destination. Snoop-type requests are never routed, and they raise an error pulse.

Top module: `xbar_req_path`

## Requirements
- R1: A request whose address lies in `[rng_base[t], rng_limit[t])` goes to target `t`. When several windows contain the address, the lowest `t` wins.
- R2: A request that matches no window goes to destination index `N_TGT`, the catch-all port (2 with the default parameters).
- R3: A forwarded request shows `dst_hdly = src_hdly + FE_LAT + FWD_LAT` (5 becomes 8 by default). A request that was first refused and later forwarded gets this sum once, not twice.
- R4: After an accept, the layer refuses new requests for `ceil(bytes/BEAT_BYTES)` further cycles when the request has data, and for 0 further cycles when it has none.
- R5: A source refused by a layer gets a `src_retry` pulse 1 cycle after the first cycle in which that layer is free. In that pulse cycle, a repeated request from the source is accepted.
- R6: When a target drops `dst_ready` while `dst_valid` is high, its layer forwards nothing until `dst_retry` for that same port is seen. A retry on any other port has no effect on this layer.
- R7: While several sources wait on one layer, retry pulses go out in round-robin order, starting just after the most recently served source.
- R8: Each accept adds 1 to `pkt_cnt[src][dst]`. It adds `src_bytes` to `byte_cnt[src][dst]` when `src_has_data` is 1 and adds 0 otherwise. Refused requests change neither counter.
- R9: A request with `src_snoop` high is never forwarded or accepted, and `bad_req` is 1 in the following cycle.
- R10: Requests from different sources to different destinations are all accepted in the same cycle.
- R11: After reset the counters are 0, and `src_ready`, `src_retry`, `dst_valid` and `bad_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rng_base | input | N_TGT*ADDR_W | Inclusive window base for each target |
| rng_limit | input | N_TGT*ADDR_W | Exclusive window limit for each target |
| src_valid | input | N_SRC | Request present on each source |
| src_snoop | input | N_SRC | Request is of snoop type (illegal) |
| src_has_data | input | N_SRC | Request carries a payload |
| src_addr | input | N_SRC*ADDR_W | Request address |
| src_bytes | input | N_SRC*LEN_W | Payload size in bytes |
| src_hdly | input | N_SRC*HDLY_W | Accumulated header delay in cycles |
| src_ready | output | N_SRC | Request accepted this cycle |
| src_retry | output | N_SRC | Retry opportunity for a refused source |
| dst_valid | output | N_DST | Request offered to each destination |
| dst_has_data | output | N_DST | Offered request carries a payload |
| dst_addr | output | N_DST*ADDR_W | Offered address |
| dst_bytes | output | N_DST*LEN_W | Offered payload size |
| dst_hdly | output | N_DST*HDLY_W | Offered header delay including crossbar latency |
| dst_ready | input | N_DST | Destination takes the offered request |
| dst_retry | input | N_DST | Destination is ready again after a refusal |
| pkt_cnt | output | N_SRC*N_DST*CNT_W | Accepted packet count per pair |
| byte_cnt | output | N_SRC*N_DST*CNT_W | Accepted byte count per pair |
| bad_req | output | 1 | A snoop or unroutable request was seen last cycle |

## Verification
Routing, `dst_valid`, `dst_hdly` and `src_ready` are combinational in the request cycle, so the bench checks them one time unit after driving the inputs. The counters and `bad_req` change at the accepting edge and are checked at the next falling edge. `src_retry` follows the first free cycle by exactly one cycle. The bench therefore counts the cycles from an accept to the waiting source's retry pulse, and compares that count with the payload beat count plus the grant cycle. For target refusals, the bench checks cycle by cycle that the layer stays silent through a retry on another port and wakes only on its own retry.

// File: rtl/xbar_req_pkg.sv
package xbar_req_pkg;

    localparam int unsigned DEF_BEAT_BYTES = 4;

    // occupancy mode of one destination layer
    typedef enum logic [1:0] {
        LYR_OPEN      = 2'd0,
        LYR_DRAIN     = 2'd1,
        LYR_PEER_HOLD = 2'd2
    } lyr_mode_e;

    // number of payload beats a request keeps the layer busy after its accept edge
    function automatic int unsigned beat_count(input int unsigned nbytes,
                                               input logic        carries_data,
                                               input int unsigned beat_bytes);
        if (!carries_data) return 0;
        return (nbytes + beat_bytes - 1) / beat_bytes;
    endfunction

    // successor index in a ring of n entries
    function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/xbar_addr_decode.sv
module xbar_addr_decode #(
    parameter int N_TGT       = 2,
    parameter int ADDR_W      = 16,
    parameter bit HAS_DEFAULT = 1'b1,
    parameter int DST_W       = 2
) (
    input  logic [ADDR_W-1:0]             addr,
    input  logic [N_TGT-1:0][ADDR_W-1:0]  base,
    input  logic [N_TGT-1:0][ADDR_W-1:0]  limit,
    output logic [DST_W-1:0]              dst,
    output logic                          hit
);
    logic             win_hit;
    logic [DST_W-1:0] win_dst;

    // scan from the top so the lowest matching window is the last one written
    always_comb begin
        win_hit = 1'b0;
        win_dst = '0;
        for (int t = N_TGT - 1; t >= 0; t--) begin
            if (addr >= base[t] && addr < limit[t]) begin
                win_hit = 1'b1;
                win_dst = DST_W'(t);
            end
        end
    end

    generate
        if (HAS_DEFAULT) begin : g_catch_all
            assign hit = 1'b1;
            assign dst = win_hit ? win_dst : DST_W'(N_TGT);
        end else begin : g_no_catch_all
            assign hit = win_hit;
            assign dst = win_dst;
        end
    endgenerate
endmodule

// File: rtl/xbar_req_layer.sv
module xbar_req_layer
    import xbar_req_pkg::*;
#(
    parameter int N_SRC      = 3,
    parameter int LEN_W      = 8,
    parameter int BEAT_BYTES = DEF_BEAT_BYTES,
    localparam int SRC_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_SRC-1:0]             req,
    input  logic [N_SRC-1:0][LEN_W-1:0]  req_bytes,
    input  logic [N_SRC-1:0]             req_has_data,
    input  logic                         peer_ready,
    input  logic                         peer_retry,
    output logic                         fwd_valid,
    output logic [SRC_W-1:0]             fwd_sel,
    output logic [N_SRC-1:0]             accept_vec,
    output logic [N_SRC-1:0]             retry_vec
);
    logic [LEN_W-1:0] busy_q;
    logic             peer_hold_q;
    logic             tok_vld_q;
    logic [SRC_W-1:0] tok_src_q;
    logic [SRC_W-1:0] rr_q;
    logic [N_SRC-1:0] wait_q;
    logic [N_SRC-1:0] retry_q;

    lyr_mode_e        mode;
    logic [N_SRC-1:0] pool;
    logic [SRC_W-1:0] gsel;
    logic             issue;
    logic             grant;
    logic [N_SRC-1:0] gbit;
    logic [LEN_W-1:0] beats_sel;

    function automatic logic [SRC_W-1:0] pick(input logic [N_SRC-1:0] m,
                                              input logic [SRC_W-1:0] p);
        logic [SRC_W-1:0] r;
        logic             f;
        int               idx;
        r = '0;
        f = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            idx = (int'(p) + k) % N_SRC;
            if (!f && m[idx]) begin
                r = SRC_W'(idx);
                f = 1'b1;
            end
        end
        return r;
    endfunction

    always_comb begin
        if (peer_hold_q)       mode = LYR_PEER_HOLD;
        else if (busy_q != '0) mode = LYR_DRAIN;
        else                   mode = LYR_OPEN;

        pool       = tok_vld_q ? (req & (N_SRC'(1) << tok_src_q)) : req;
        fwd_sel    = pick(pool, rr_q);
        gsel       = pick(wait_q, rr_q);
        // a granted retry owns the layer; otherwise waiters are served before newcomers
        issue      = (mode == LYR_OPEN) && (tok_vld_q || wait_q == '0) && (pool != '0);
        grant      = (mode == LYR_OPEN) && !tok_vld_q && (wait_q != '0);
        gbit       = grant ? (N_SRC'(1) << gsel) : '0;
        fwd_valid  = issue;
        accept_vec = (issue && peer_ready) ? (N_SRC'(1) << fwd_sel) : '0;
        beats_sel  = LEN_W'(beat_count(32'(req_bytes[fwd_sel]), req_has_data[fwd_sel],
                                       BEAT_BYTES));
    end

    assign retry_vec = retry_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= '0;
            peer_hold_q <= 1'b0;
            tok_vld_q   <= 1'b0;
            tok_src_q   <= '0;
            rr_q        <= '0;
            wait_q      <= '0;
            retry_q     <= '0;
        end else begin
            if (accept_vec != '0)  busy_q <= beats_sel;
            else if (busy_q != '0) busy_q <= busy_q - 1'b1;

            if (issue && !peer_ready) peer_hold_q <= 1'b1;
            else if (peer_retry)      peer_hold_q <= 1'b0;

            if (grant) begin
                tok_vld_q <= 1'b1;
                tok_src_q <= gsel;
            end else if (accept_vec != '0) begin
                tok_vld_q <= 1'b0;
            end

            if (accept_vec != '0) rr_q <= SRC_W'(ring_next(32'(fwd_sel), N_SRC));
            else if (grant)       rr_q <= SRC_W'(ring_next(32'(gsel), N_SRC));

            wait_q  <= (wait_q | req) & ~accept_vec & ~gbit;
            retry_q <= gbit;
        end
    end

    // R4: an occupied layer counts down one beat per cycle
    a_r4_drain_countdown: assert property (@(posedge clk) disable iff (rst)
        (busy_q != '0) |=> (busy_q == $past(busy_q) - 1'b1));

    // R6: a refused target keeps the layer held until its own retry arrives
    a_r6_hold_until_retry: assert property (@(posedge clk) disable iff (rst)
        (peer_hold_q && !peer_retry) |=> peer_hold_q);

    // R6: nothing is offered to a target that is being waited on
    a_r6_silent_in_hold: assert property (@(posedge clk) disable iff (rst)
        peer_hold_q |-> !fwd_valid);

    // R5: a retry pulse always comes with the layer reserved for its receiver
    a_r5_retry_reserves: assert property (@(posedge clk) disable iff (rst)
        (retry_q != '0) |-> (tok_vld_q && retry_q == (N_SRC'(1) << tok_src_q)));

    // R7: retry pulses go to one source at a time
    a_r7_single_retry: assert property (@(posedge clk) disable iff (rst)
        $onehot0(retry_q));
endmodule

// File: rtl/xbar_pkt_stats.sv
module xbar_pkt_stats #(
    parameter int N_SRC = 3,
    parameter int N_DST = 3,
    parameter int LEN_W = 8,
    parameter int CNT_W = 16
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_DST-1:0][N_SRC-1:0]            acc,
    input  logic [N_SRC-1:0][LEN_W-1:0]            bytes,
    input  logic [N_SRC-1:0]                       has_data,
    output logic [N_SRC-1:0][N_DST-1:0][CNT_W-1:0] pkt_cnt,
    output logic [N_SRC-1:0][N_DST-1:0][CNT_W-1:0] byte_cnt
);
    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            for (genvar d = 0; d < N_DST; d++) begin : g_dst
                always_ff @(posedge clk) begin
                    if (rst) begin
                        pkt_cnt[s][d]  <= '0;
                        byte_cnt[s][d] <= '0;
                    end else if (acc[d][s]) begin
                        pkt_cnt[s][d]  <= pkt_cnt[s][d] + 1'b1;
                        if (has_data[s])
                            byte_cnt[s][d] <= byte_cnt[s][d] + CNT_W'(bytes[s]);
                    end
                end

                // R8: the pair's counters move only on an accept for that pair
                a_r8_quiet_pair: assert property (@(posedge clk) disable iff (rst)
                    !acc[d][s] |=> ($stable(pkt_cnt[s][d]) && $stable(byte_cnt[s][d])));
            end
        end
    endgenerate
endmodule

// File: rtl/xbar_req_path.sv
module xbar_req_path
    import xbar_req_pkg::*;
#(
    parameter int N_SRC       = 3,
    parameter int N_TGT       = 2,
    parameter bit HAS_DEFAULT = 1'b1,
    parameter int ADDR_W      = 16,
    parameter int LEN_W       = 8,
    parameter int HDLY_W      = 8,
    parameter int CNT_W       = 16,
    parameter int BEAT_BYTES  = DEF_BEAT_BYTES,
    parameter int FE_LAT      = 2,
    parameter int FWD_LAT     = 1,
    localparam int N_DST      = N_TGT + (HAS_DEFAULT ? 1 : 0),
    localparam int DST_W      = (N_DST > 1) ? $clog2(N_DST + 1) : 1,
    localparam int SRC_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_TGT-1:0][ADDR_W-1:0]           rng_base,
    input  logic [N_TGT-1:0][ADDR_W-1:0]           rng_limit,
    input  logic [N_SRC-1:0]                       src_valid,
    input  logic [N_SRC-1:0]                       src_snoop,
    input  logic [N_SRC-1:0]                       src_has_data,
    input  logic [N_SRC-1:0][ADDR_W-1:0]           src_addr,
    input  logic [N_SRC-1:0][LEN_W-1:0]            src_bytes,
    input  logic [N_SRC-1:0][HDLY_W-1:0]           src_hdly,
    output logic [N_SRC-1:0]                       src_ready,
    output logic [N_SRC-1:0]                       src_retry,
    output logic [N_DST-1:0]                       dst_valid,
    output logic [N_DST-1:0]                       dst_has_data,
    output logic [N_DST-1:0][ADDR_W-1:0]           dst_addr,
    output logic [N_DST-1:0][LEN_W-1:0]            dst_bytes,
    output logic [N_DST-1:0][HDLY_W-1:0]           dst_hdly,
    input  logic [N_DST-1:0]                       dst_ready,
    input  logic [N_DST-1:0]                       dst_retry,
    output logic [N_SRC-1:0][N_DST-1:0][CNT_W-1:0] pkt_cnt,
    output logic [N_SRC-1:0][N_DST-1:0][CNT_W-1:0] byte_cnt,
    output logic                                   bad_req
);
    localparam logic [HDLY_W-1:0] XBAR_LAT = HDLY_W'(FE_LAT + FWD_LAT);

    logic [N_SRC-1:0][DST_W-1:0] route;
    logic [N_SRC-1:0]            routed;
    logic [N_DST-1:0][N_SRC-1:0] req_m;
    logic [N_DST-1:0][N_SRC-1:0] acc_m;
    logic [N_DST-1:0][N_SRC-1:0] rty_m;
    logic [N_DST-1:0][SRC_W-1:0] sel_d;
    logic                        bad_q;

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_dec
            xbar_addr_decode #(
                .N_TGT(N_TGT), .ADDR_W(ADDR_W), .HAS_DEFAULT(HAS_DEFAULT), .DST_W(DST_W)
            ) u_dec (
                .addr(src_addr[s]), .base(rng_base), .limit(rng_limit),
                .dst(route[s]), .hit(routed[s])
            );
        end

        for (genvar d = 0; d < N_DST; d++) begin : g_lyr
            for (genvar s = 0; s < N_SRC; s++) begin : g_req
                assign req_m[d][s] = src_valid[s] && !src_snoop[s] && routed[s]
                                     && (route[s] == DST_W'(d));
            end

            xbar_req_layer #(
                .N_SRC(N_SRC), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)
            ) u_lyr (
                .clk(clk), .rst(rst),
                .req(req_m[d]), .req_bytes(src_bytes), .req_has_data(src_has_data),
                .peer_ready(dst_ready[d]), .peer_retry(dst_retry[d]),
                .fwd_valid(dst_valid[d]), .fwd_sel(sel_d[d]),
                .accept_vec(acc_m[d]), .retry_vec(rty_m[d])
            );

            assign dst_addr[d]     = src_addr[sel_d[d]];
            assign dst_bytes[d]    = src_bytes[sel_d[d]];
            assign dst_has_data[d] = src_has_data[sel_d[d]];
            assign dst_hdly[d]     = src_hdly[sel_d[d]] + XBAR_LAT;
        end
    endgenerate

    always_comb begin
        src_ready = '0;
        src_retry = '0;
        for (int d = 0; d < N_DST; d++) begin
            src_ready = src_ready | acc_m[d];
            src_retry = src_retry | rty_m[d];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bad_q <= 1'b0;
        else     bad_q <= |(src_valid & (src_snoop | ~routed));
    end
    assign bad_req = bad_q;

    xbar_pkt_stats #(
        .N_SRC(N_SRC), .N_DST(N_DST), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_stats (
        .clk(clk), .rst(rst), .acc(acc_m), .bytes(src_bytes), .has_data(src_has_data),
        .pkt_cnt(pkt_cnt), .byte_cnt(byte_cnt)
    );

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_chk
            // R10: an accept is only ever given to a live, legal request
            a_r10_ready_needs_req: assert property (@(posedge clk) disable iff (rst)
                src_ready[s] |-> (src_valid[s] && !src_snoop[s]));
        end
    endgenerate

    // R9: a snoop-type request is flagged in the following cycle
    a_r9_snoop_flagged: assert property (@(posedge clk) disable iff (rst)
        (|(src_valid & src_snoop)) |=> bad_req);
endmodule

// File: tb/xbar_req_path_bench.sv
module xbar_req_path_bench;
    localparam int NS = 3;
    localparam int ND = 3;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [1:0][15:0]      rng_base;
    logic [1:0][15:0]      rng_limit;
    logic [NS-1:0]         src_valid, src_snoop, src_has_data;
    logic [NS-1:0][15:0]   src_addr;
    logic [NS-1:0][7:0]    src_bytes;
    logic [NS-1:0][7:0]    src_hdly;
    logic [NS-1:0]         src_ready, src_retry;
    logic [ND-1:0]         dst_valid, dst_has_data;
    logic [ND-1:0][15:0]   dst_addr;
    logic [ND-1:0][7:0]    dst_bytes;
    logic [ND-1:0][7:0]    dst_hdly;
    logic [ND-1:0]         dst_ready, dst_retry;
    logic [NS-1:0][ND-1:0][15:0] pkt_cnt, byte_cnt;
    logic                  bad_req;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    xbar_req_path u_xbar_req_path (
        .clk(clk), .rst(rst), .rng_base(rng_base), .rng_limit(rng_limit),
        .src_valid(src_valid), .src_snoop(src_snoop), .src_has_data(src_has_data),
        .src_addr(src_addr), .src_bytes(src_bytes), .src_hdly(src_hdly),
        .src_ready(src_ready), .src_retry(src_retry),
        .dst_valid(dst_valid), .dst_has_data(dst_has_data), .dst_addr(dst_addr),
        .dst_bytes(dst_bytes), .dst_hdly(dst_hdly),
        .dst_ready(dst_ready), .dst_retry(dst_retry),
        .pkt_cnt(pkt_cnt), .byte_cnt(byte_cnt), .bad_req(bad_req)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [1:0]  dst;
    } vec_t;

    // window 0 = [0x1000,0x2000), window 1 = [0x1800,0x4000), catch-all = 2
    localparam vec_t VECS [8] = '{
        '{16'h1000, 2'd0}, '{16'h1FFF, 2'd0}, '{16'h1800, 2'd0}, '{16'h2000, 2'd1},
        '{16'h3FFF, 2'd1}, '{16'h4000, 2'd2}, '{16'h0FFF, 2'd2}, '{16'h0000, 2'd2}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        src_valid = '0; src_snoop = '0; dst_retry = '0; dst_ready = '1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rng_base  = '{16'h1800, 16'h1000};
        rng_limit = '{16'h4000, 16'h2000};
        src_valid = '0; src_snoop = '0; src_has_data = '0;
        src_addr = '0; src_bytes = '0; src_hdly = '0;
        dst_ready = '1; dst_retry = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        #1;
        chk("R11 pkt_cnt", 64'(pkt_cnt), 64'd0);
        chk("R11 byte_cnt", 64'(byte_cnt), 64'd0);
        chk("R11 ready/retry", {src_ready, src_retry}, 0);
        chk("R11 dst_valid/bad_req", {dst_valid, bad_req}, 0);

        // R8: counters per pair, data-less size counted as 0
        src_valid[2] = 1'b1; src_addr[2] = 16'h2000; src_bytes[2] = 8'd7; src_has_data[2] = 1'b1;
        step();
        src_valid[2] = 1'b0;
        chk("R8 pkt after first", pkt_cnt[2][1], 1);
        chk("R8 bytes after first", byte_cnt[2][1], 7);
        repeat (4) step();
        src_valid[2] = 1'b1; src_bytes[2] = 8'd5; src_has_data[2] = 1'b0;
        step();
        src_valid[2] = 1'b0;
        chk("R8 pkt after dataless", pkt_cnt[2][1], 2);
        chk("R8 bytes after dataless", byte_cnt[2][1], 7);
        chk("R8 other pair untouched", pkt_cnt[0][1], 0);
        step();
        dst_ready[1] = 1'b0;
        src_valid[2] = 1'b1;
        step();
        src_valid[2] = 1'b0;
        chk("R8 refused not counted", pkt_cnt[2][1], 2);

        do_reset();

        // R1 R2 R3: decode table walk
        src_hdly[0] = 8'd5; src_has_data[0] = 1'b0; src_bytes[0] = 8'd0;
        foreach (VECS[i]) begin
            src_valid[0] = 1'b1;
            src_addr[0]  = VECS[i].addr;
            #1;
            chk(VECS[i].dst == 2'd2 ? "R2 catch-all route" : "R1 window route",
                dst_valid, 3'b001 << VECS[i].dst);
            chk("R3 header delay", dst_hdly[VECS[i].dst], 8'd8);
            chk("R1 accepted", src_ready[0], 1);
            step();
            src_valid[0] = 1'b0;
            step();
        end

        // R4 R5: occupied layer, refused waiter, retry pulse then accept
        begin
            int acc_k = 0;
            int rty_k = 0;
            src_valid[0] = 1'b1; src_addr[0] = 16'h1000; src_bytes[0] = 8'd9; src_has_data[0] = 1'b1;
            #1;
            chk("R4 first accept", src_ready[0], 1);
            step();
            src_valid[0] = 1'b0;
            src_valid[1] = 1'b1; src_addr[1] = 16'h1100; src_bytes[1] = 8'd0; src_has_data[1] = 1'b0;
            for (int k = 1; k <= 8; k++) begin
                #1;
                if (src_ready[1] && acc_k == 0) acc_k = k;
                if (src_retry[1] && rty_k == 0) rty_k = k;
                step();
                if (acc_k != 0) src_valid[1] = 1'b0;
            end
            chk("R4 waiter accepted after 3 beats + grant", acc_k, 5);
            chk("R5 retry pulse cycle", rty_k, 5);
        end

        // R6 R3: target refusal, foreign retry ignored, own retry releases
        dst_ready = 3'b101;
        src_valid[0] = 1'b1; src_addr[0] = 16'h2000; src_bytes[0] = 8'd0; src_has_data[0] = 1'b0;
        #1;
        chk("R6 offered before refusal", dst_valid[1], 1);
        chk("R6 not accepted", src_ready[0], 0);
        step();
        chk("R6 held after refusal", dst_valid[1], 0);
        dst_ready = 3'b111;
        dst_retry = 3'b001;
        step();
        dst_retry = 3'b000;
        chk("R6 foreign retry ignored", dst_valid[1], 0);
        chk("R6 still no accept", src_ready[0], 0);
        dst_retry = 3'b010;
        step();
        dst_retry = 3'b000;
        chk("R5 grant cycle no offer", dst_valid[1], 0);
        step();
        chk("R5 retry after release", src_retry[0], 1);
        chk("R6 accepted after own retry", src_ready[0], 1);
        chk("R3 delay not doubled", dst_hdly[1], 8'd8);
        step();
        src_valid[0] = 1'b0;
        step();

        // R7: three waiters served round robin, starting after source 0
        begin
            logic [2:0] active;
            int order [3];
            int n = 0;
            src_valid[0] = 1'b1; src_addr[0] = 16'h1000; src_bytes[0] = 8'd8; src_has_data[0] = 1'b1;
            #1;
            chk("R7 opener accepted", src_ready[0], 1);
            step();
            src_bytes = '0; src_has_data = '0;
            src_addr[1] = 16'h1000; src_addr[2] = 16'h1000;
            active = 3'b111;
            src_valid = active;
            for (int c = 0; c < 12; c++) begin
                #1;
                for (int s = 0; s < 3; s++) begin
                    if (src_ready[s] && n < 3) begin
                        order[n] = s;
                        n++;
                        active[s] = 1'b0;
                    end
                end
                step();
                src_valid = active;
            end
            chk("R7 served count", n, 3);
            chk("R7 first", order[0], 1);
            chk("R7 second", order[1], 2);
            chk("R7 third", order[2], 0);
        end

        // R10: three destinations accepted in one cycle
        src_addr[0] = 16'h1000; src_addr[1] = 16'h2000; src_addr[2] = 16'h5000;
        src_valid = 3'b111;
        #1;
        chk("R10 parallel accepts", src_ready, 3'b111);
        step();
        src_valid = '0;
        step();

        // R9: snoop never forwarded, flagged next cycle
        src_valid[1] = 1'b1; src_snoop[1] = 1'b1; src_addr[1] = 16'h1000;
        #1;
        chk("R9 snoop not offered", dst_valid, 0);
        chk("R9 snoop not accepted", src_ready, 0);
        step();
        src_valid[1] = 1'b0; src_snoop[1] = 1'b0;
        chk("R9 flag raised", bad_req, 1);
        step();
        chk("R9 flag clears", bad_req, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule